// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a synthesizable, cycle-accurate model of a pipelined synchronous static RAM. Its data bus can switch between reads and writes on consecutive cycles with no idle cycle between them. Every input is sampled on the rising clock edge: address, access controls, the three chip selects, the byte-lane write strobes and the write data.

The block sets read and write latency to the same value. An access is issued on one edge, and its data moves on the bus in the slot that the second following active edge closes. A read returns data on the output register at that edge. A write samples its data at that edge and holds it in a pending register, and the array takes it on the next active edge. A read that arrives while its word is still pending receives the pending bytes merged over the array contents.

The two low address bits can step through a four-beat burst, in either linear or interleaved order. Clock suspend freezes the whole block. The sleep input freezes it and also turns the outputs off, with a two-edge delay on entry and on exit. The bus has no tri-state pins: the block drives `rdata` together with a drive-enable `out_en`, and the integrating level builds the pad from the two.

Top module: `nw_sram`

## Requirements
- R1: After reset `out_en` is 0 and every array word reads as zero.
- R2: An access is issued only on an edge where `advance` is 0 and the chip is selected, meaning `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. An edge with `advance`=0 and any other select pattern issues a deselect, which neither writes the array nor drives the bus.
- R3: A read issued on active edge N places the word on `rdata` after active edge N+2. If `oe_n`=0 and the block is awake, `out_en` is 1 during that slot.
- R4: A write issued on active edge N samples `wdata` at active edge N+2. `bw_n[i]`=0 enables bits [8i+7:8i]. A write with every `bw_n` bit at 1 leaves the array unchanged.
- R5: An edge with `advance`=1 repeats the previous operation type (read, write or deselect) at the next burst address. The upper address bits stay fixed. With `burst_ilv`=0 the low two bits are (start + k) mod 4. With `burst_ilv`=1 they are start XOR k, where k is the beat number, 1 to 3.
- R6: A read of a word whose write data is still pending returns the pending bytes for the enabled lanes and the array bytes for the other lanes.
- R7: On an edge with `cken_n`=1, all inputs are ignored and every register keeps its value, including the burst position and the output register.
- R8: `out_en` is 1 only in a read slot with `oe_n`=0. `oe_n` acts combinationally, with no clock edge needed, and a read made with `oe_n`=1 still advances the pipeline.
- R9: When `sleep` is first seen high on edge K, edge K+1 still acts and every edge from K+2 on is ignored. `out_en` is 0 while asleep. When `sleep` is first seen low on edge M, edge M+1 is still ignored and edge M+2 acts. The pipeline resumes from the state it held.
- R10: A read may be issued on the edge right after a write, and a write right after a read, with no idle edge between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cken_n | input | 1 | High suspends the block for that edge |
| sleep | input | 1 | Sleep request, takes effect two edges after it is seen |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| advance | input | 1 | 0 loads a new access, 1 steps the current burst |
| wr_n | input | 1 | 0 makes a loaded access a write |
| bw_n | input | DW/8 | Per-lane write strobes, active low |
| burst_ilv | input | 1 | 1 selects interleaved burst order, 0 linear |
| oe_n | input | 1 | Output enable, active low, combinational |
| addr | input | AW | Word address |
| wdata | input | DW | Write data, sampled two active edges after its address |
| rdata | output | DW | Registered read data |
| out_en | output | 1 | Drive enable for the data bus |

## Verification
A corrupted pipeline stage shows up at the ports exactly two active edges after the access it carries. It appears as a wrong word on `rdata` or as `out_en` in the wrong slot. A bad burst step returns another word of the same four-word group on the following beats, because the reference array holds distinct values at every address. A pending write that is lost or committed twice is visible only on a read that hits that word: a read one edge later exposes a missing bypass, and a later read exposes a missing commit. Suspend and sleep faults appear as an output change on an edge that should have been frozen, or as a result that is one slot early or late after resume.

// File: rtl/nw_sram.sv
module nw_sram #(
  parameter int DW = 16,
  parameter int AW = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cken_n,
  input  logic             sleep,
  input  logic             sel_a_n,
  input  logic             sel_b,
  input  logic             sel_c_n,
  input  logic             advance,
  input  logic             wr_n,
  input  logic [DW/8-1:0]  bw_n,
  input  logic             burst_ilv,
  input  logic             oe_n,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic             out_en
);
  localparam int LANES = DW / 8;
  localparam int DEPTH = 1 << AW;
  localparam logic [1:0] OP_IDLE = 2'd0, OP_RD = 2'd1, OP_WR = 2'd2;

  logic [1:0] zz_q;
  wire asleep = zz_q[1];
  wire go     = !cken_n && !asleep;
  wire picked = !sel_a_n && sel_b && !sel_c_n;

  logic [1:0]       op_q, cnt_q;
  logic [AW-1:0]    base_q;
  logic [1:0]       s1_op, s2_op;
  logic [AW-1:0]    s1_addr, s2_addr;
  logic [LANES-1:0] s1_bw, s2_bw;
  logic             pend_v;
  logic [AW-1:0]    pend_addr;
  logic [LANES-1:0] pend_bw;
  logic [DW-1:0]    pend_data;
  logic [DW-1:0]    rdata_q;
  logic             rd_v_q;
  logic [DW-1:0]    mem [DEPTH];
  logic [DW-1:0]    merged;

  wire [1:0]    cnt_nx     = cnt_q + 2'd1;
  wire [1:0]    lo_nx      = burst_ilv ? (base_q[1:0] ^ cnt_nx) : (base_q[1:0] + cnt_nx);
  wire [AW-1:0] burst_addr = {base_q[AW-1:2], lo_nx};
  wire [1:0]    new_op     = !picked ? OP_IDLE : (wr_n ? OP_RD : OP_WR);
  wire          hit        = pend_v && (pend_addr == s2_addr);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) zz_q <= '0;
    else        zz_q <= {zz_q[0], sleep};

  always_comb begin
    merged = mem[s2_addr];
    for (int l = 0; l < LANES; l++)
      if (hit && pend_bw[l]) merged[8*l +: 8] = pend_data[8*l +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q <= OP_IDLE; cnt_q <= '0; base_q <= '0;
      s1_op <= OP_IDLE; s1_addr <= '0; s1_bw <= '0;
      s2_op <= OP_IDLE; s2_addr <= '0; s2_bw <= '0;
      pend_v <= 1'b0; pend_addr <= '0; pend_bw <= '0; pend_data <= '0;
      rdata_q <= '0; rd_v_q <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (go) begin
      if (!advance) begin
        op_q <= new_op; base_q <= addr; cnt_q <= '0;
        s1_op <= new_op; s1_addr <= addr;
      end else begin
        cnt_q <= cnt_nx;
        s1_op <= op_q; s1_addr <= burst_addr;
      end
      s1_bw   <= ~bw_n;
      s2_op   <= s1_op; s2_addr <= s1_addr; s2_bw <= s1_bw;
      pend_v    <= (s2_op == OP_WR);
      pend_addr <= s2_addr;
      pend_bw   <= s2_bw;
      pend_data <= wdata;
      for (int l = 0; l < LANES; l++)
        if (pend_v && pend_bw[l]) mem[pend_addr][8*l +: 8] <= pend_data[8*l +: 8];
      rdata_q <= merged;
      rd_v_q  <= (s2_op == OP_RD);
    end
  end

  assign rdata  = rdata_q;
  assign out_en = rd_v_q && !oe_n && !asleep;
endmodule

// File: rtl/nw_sram_chk.sv
module nw_sram_chk #(
  parameter int DW = 16,
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          go,
  input logic          asleep,
  input logic          advance,
  input logic          sel_a_n,
  input logic          sel_b,
  input logic          sel_c_n,
  input logic          oe_n,
  input logic          out_en,
  input logic [DW-1:0] rdata,
  input logic [1:0]    s1_op,
  input logic [AW-1:0] s1_addr,
  input logic [1:0]    s2_op,
  input logic          rd_v_q
);
  AST_HOLD_ON_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> $stable(rdata) && $stable(rd_v_q) && $stable(s1_addr)); // R7
  AST_OE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !out_en); // R8
  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> !out_en); // R9
  AST_DESEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    go && !advance && !(!sel_a_n && sel_b && !sel_c_n) |=> s1_op == 2'd0); // R2
  AST_READ_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    go && s2_op == 2'd1 |=> rd_v_q); // R3
  AST_WRITE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    go && s2_op == 2'd2 |=> !rd_v_q); // R10
  AST_BURST_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    go && advance |=> s1_addr[AW-1:2] == $past(s1_addr[AW-1:2])); // R5
endmodule

bind nw_sram nw_sram_chk #(.DW(DW), .AW(AW)) u_chk (.*);

// File: tb/nw_sram_bench.sv
`timescale 1ns/100ps
module nw_sram_bench;
  localparam int DW = 16;
  localparam int AW = 5;
  localparam int NV = 27;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cken_n = 1'b0, sleep = 1'b0, sel_a_n = 1'b1, sel_b = 1'b1, sel_c_n = 1'b0;
  logic advance = 1'b1, wr_n = 1'b1, burst_ilv = 1'b0, oe_n = 1'b0;
  logic [1:0] bw_n = 2'b11;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic out_en;
  int runs = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  nw_sram #(.DW(DW), .AW(AW)) u_nw_sram (
    .clk(clk), .rst_n(rst_n), .cken_n(cken_n), .sleep(sleep),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .advance(advance), .wr_n(wr_n), .bw_n(bw_n), .burst_ilv(burst_ilv),
    .oe_n(oe_n), .addr(addr), .wdata(wdata), .rdata(rdata), .out_en(out_en)
  );

  // fields: suspend, load, selected, write, bw_n, interleave, addr, wdata, expected en, expected data
  function automatic logic [44:0] v(input logic ck, input logic ld, input logic sel,
      input logic we, input logic [1:0] bw, input logic md, input logic [4:0] a,
      input logic [15:0] d, input logic een, input logic [15:0] ed);
    return {ck, ld, sel, we, bw, md, a, d, een, ed};
  endfunction

  localparam logic [44:0] TBL [NV] = '{
    v(0,1,1,1,2'b00,0,4,16'h0000,0,16'h0000), // 0  R4 write burst from 4
    v(0,0,1,1,2'b00,0,0,16'h0000,0,16'h0000), // 1  R5
    v(0,0,1,1,2'b00,0,0,16'h1111,0,16'h0000), // 2  R4 data for 4
    v(0,0,1,1,2'b00,0,0,16'h2222,0,16'h0000), // 3
    v(0,1,1,0,2'b00,0,4,16'h3333,0,16'h0000), // 4  R10 read right after write
    v(0,0,1,0,2'b00,0,0,16'h4444,0,16'h0000), // 5
    v(0,0,1,0,2'b00,0,0,16'h0000,1,16'h1111), // 6  R3
    v(0,0,1,0,2'b00,0,0,16'h0000,1,16'h2222), // 7
    v(0,1,1,1,2'b10,0,7,16'h0000,1,16'h3333), // 8  R10 write lane0 after read
    v(0,1,1,0,2'b00,0,7,16'h0000,1,16'h4444), // 9  R10 read after write
    v(0,1,0,0,2'b00,0,0,16'hABCD,0,16'h0000), // 10 R2 deselect, lane0 data
    v(0,0,0,0,2'b00,0,0,16'h0000,1,16'h44CD), // 11 R6 merged bypass
    v(0,1,1,0,2'b00,0,5,16'h0000,0,16'h0000), // 12 R5 linear burst from 5
    v(1,1,1,1,2'b00,0,0,16'h0000,0,16'h0000), // 13 R7 suspended
    v(0,0,1,0,2'b00,0,0,16'h0000,0,16'h0000), // 14
    v(0,0,1,0,2'b00,0,0,16'h0000,1,16'h2222), // 15 R7 shifted one slot
    v(0,0,1,0,2'b00,0,0,16'h0000,1,16'h3333), // 16
    v(0,1,1,0,2'b00,1,5,16'h0000,1,16'h44CD), // 17 R5 interleaved from 5
    v(0,0,1,0,2'b00,1,0,16'h0000,1,16'h1111), // 18 wrap 5,6,7,4
    v(0,0,1,0,2'b00,1,0,16'h0000,1,16'h2222), // 19
    v(0,0,1,0,2'b00,1,0,16'h0000,1,16'h1111), // 20 interleaved 5,4,7,6
    v(0,1,0,0,2'b00,0,0,16'h0000,1,16'h44CD), // 21
    v(0,0,0,0,2'b00,0,0,16'h0000,1,16'h3333), // 22
    v(0,1,1,1,2'b11,0,4,16'h0000,0,16'h0000), // 23 R4 write abort
    v(0,1,1,0,2'b00,0,4,16'h0000,0,16'h0000), // 24
    v(0,1,0,0,2'b00,0,0,16'hFFFF,0,16'h0000), // 25 data offered to abort
    v(0,0,0,0,2'b00,0,0,16'h0000,1,16'h1111)  // 26 R4 word unchanged
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_en(input string tag, input logic exp);
    runs++;
    if (out_en !== exp) begin
      fails++;
      $display("FAIL %s out_en actual=%0b expected=%0b", tag, out_en, exp);
    end
  endtask

  task automatic chk_word(input string tag, input logic [DW-1:0] exp);
    runs++;
    if (out_en !== 1'b1 || rdata !== exp) begin
      fails++;
      $display("FAIL %s out_en=%0b rdata actual=%h expected=%h", tag, out_en, rdata, exp);
    end
  endtask

  task automatic drive(input logic ck, input logic ld, input logic sel, input logic we,
      input logic [1:0] bw, input logic [AW-1:0] a, input logic [DW-1:0] d);
    cken_n = ck; advance = !ld; wr_n = !we; bw_n = bw; addr = a; wdata = d;
    sel_a_n = !sel; sel_b = 1'b1; sel_c_n = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    #12;
    chk_en("R1 reset", 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_en("R1 after release", 1'b0);

    for (int i = 0; i < NV; i++) begin
      logic [44:0] e;
      e = TBL[i];
      drive(e[44], e[43], e[42], e[41], e[40:39], e[37:33], e[32:17]);
      burst_ilv = e[38];
      tick();
      if (e[16]) chk_word($sformatf("R3 R5 R6 vector %0d", i), e[15:0]);
      else       chk_en($sformatf("R2 R4 R7 R10 vector %0d", i), 1'b0);
    end

    // R1: untouched word reads zero
    drive(0,1,1,0,2'b00,20,0); tick();
    drive(0,0,0,0,2'b00,0,0);  tick(); tick();
    chk_word("R1 unwritten word", 16'h0000);

    // R8: dummy read, then asynchronous enable
    oe_n = 1'b1;
    drive(0,1,1,0,2'b00,5,0); tick();
    drive(0,1,0,0,2'b00,0,0); tick(); tick();
    chk_en("R8 dummy read", 1'b0);
    oe_n = 1'b0;
    #1;
    chk_word("R8 async enable", 16'h2222);
    @(negedge clk);
    tick();

    // R2: write with second select inactive
    drive(0,1,1,1,2'b00,4,0); sel_b = 1'b0; tick();
    drive(0,1,0,0,2'b00,0,0); tick();
    drive(0,1,0,0,2'b00,0,16'h7777); tick();
    drive(0,1,0,0,2'b00,0,0); tick();
    drive(0,1,1,0,2'b00,4,0); tick();
    drive(0,1,0,0,2'b00,0,0); tick(); tick();
    chk_word("R2 deselected write ignored", 16'h1111);
    tick();

    // R9: sleep with a read in flight and a write offered while asleep
    sleep = 1'b1;
    drive(0,1,1,0,2'b00,4,0); tick();
    drive(0,1,0,0,2'b00,0,0); tick();
    drive(0,1,1,1,2'b00,4,16'h9999); tick();
    chk_en("R9 frozen entering sleep", 1'b0);
    tick(); tick();
    sleep = 1'b0;
    tick(); tick();
    chk_en("R9 still asleep one edge after release", 1'b0);
    drive(0,1,0,0,2'b00,0,0); tick();
    chk_word("R9 resumed pipeline", 16'h1111);
    tick();
    drive(0,1,1,0,2'b00,4,0); tick();
    drive(0,1,0,0,2'b00,0,0); tick(); tick();
    chk_word("R9 write during sleep ignored", 16'h1111);

    summary();
  end
endmodule